// File: doc/BRIEF.md
# Dual-Width Register Slave Port

This block is a synchronous, SRAM-style slave port through which a host processor reads and writes a bank of 1024 registers, each 32 bits wide. Locations 0 to 511 form the configuration area and locations 512 to 1023 form the operating-register area. Both areas are plain storage here; what the registers mean is left to the logic around the port.

A static mode input picks the bus width. In narrow mode each access touches one 32-bit location. In wide mode each access touches an aligned even/odd pair of locations, with the low data half going to the even one.

The port is selected only when three chip enables of mixed polarity all agree. A direction input chooses read or write. Writes are qualified per byte lane and by a master byte-write enable. Read data is registered and placed on the bus only while the asynchronous output enable is active.

Top module: `dwr_port_top`

## Requirements
- R1: A synchronous active-high reset clears every register location and the read data register to zero.
- R2: The port is selected only when `sel_a_n` is 0, `sel_b_n` is 0 and `sel_c` is 1. When it is not selected, writes change no location and the read data register holds its value.
- R3: When selected, `rd_wr_n` = 0 makes the cycle a write, sampled on the rising clock edge. `rd_wr_n` = 1 makes it a read, and its data appears on `rdata` after that same rising edge, one cycle after the inputs are applied.
- R4: Lane strobe `lane_we_n[k]` (active low) writes byte k, data bits [8k+7:8k]. Bytes whose strobes are high keep their old value.
- R5: While the master byte-write enable `byte_en_n` is high, a selected write changes nothing.
- R6: In narrow mode (`wide_mode` = 0) all 10 address bits pick the location. Only `wdata[31:0]` and `lane_we_n[3:0]` are used; `lane_we_n[7:4]` have no effect, and `rdata[63:32]` reads as zero.
- R7: In wide mode (`wide_mode` = 1) address bit 0 is ignored. `wdata[31:0]` and lanes 3..0 map to the even location, and `wdata[63:32]` and lanes 7..4 map to the odd location. Reads return {odd, even}.
- R8: `oe_n` acts without a clock. `bus_drive` equals the inverse of `oe_n`, and `rdata` reads zero while `oe_n` is high. A read performed while `oe_n` is high still loads the read data register.
- R9: The configuration area (0–511) and the operating area (512–1023) are distinct storage: writing one location leaves a location in the other area unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wide_mode | input | 1 | 1 = 64-bit bus, 0 = 32-bit bus (static) |
| addr | input | 10 | 32-bit location address |
| wdata | input | 64 | Write data |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| lane_we_n | input | 8 | Per-byte write strobes, active low |
| byte_en_n | input | 1 | Master byte-write enable, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | 64 | Read data, zero when not driven |
| bus_drive | output | 1 | High while the data bus is driven |

## Verification
A write takes effect on the rising edge where it is sampled, so it is visible to a read issued in the next cycle. Read data becomes visible one rising edge after the read inputs are applied. The bench drives every access on the falling edge. The monitor compares `rdata` 1 ns after the next rising edge, while that read is still flagged as issued, so each expected item in the queue is matched against the exact cycle that produced it. Output-enable effects involve no clock and are checked 1 ns after `oe_n` changes.

// File: rtl/dwr_pkg.sv
package dwr_pkg;
    parameter int ADDR_W  = 10;
    parameter int WORD_W  = 32;
    localparam int LOCS    = 1 << ADDR_W;
    localparam int LANES   = WORD_W / 8;
    localparam int BUS_W   = 2 * WORD_W;
    localparam int BUS_LN  = 2 * LANES;

    typedef logic [ADDR_W-1:0] idx_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lanes_t;

    // decoded access for one cycle
    typedef struct packed {
        logic   rd;
        logic   wide;
        idx_t   idx_lo;
        idx_t   idx_hi;
        lanes_t be_lo;
        lanes_t be_hi;
        word_t  d_lo;
        word_t  d_hi;
    } acc_t;

    function automatic word_t merge_bytes(word_t old_w, word_t new_w, lanes_t be);
        word_t r;
        for (int k = 0; k < LANES; k++)
            r[8*k +: 8] = be[k] ? new_w[8*k +: 8] : old_w[8*k +: 8];
        return r;
    endfunction
endpackage

// File: rtl/dwr_decode.sv
module dwr_decode
    import dwr_pkg::*;
(
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              rd_wr_n,
    input  logic [BUS_LN-1:0] lane_we_n,
    input  logic              byte_en_n,
    output logic              selected,
    output acc_t              acc
);
    logic wr_ok;
    idx_t base;

    always_comb begin
        selected = !sel_a_n && !sel_b_n && sel_c;
        wr_ok    = selected && !rd_wr_n && !byte_en_n;
        base     = wide_mode ? {addr[ADDR_W-1:1], 1'b0} : addr;

        acc.rd     = selected && rd_wr_n;
        acc.wide   = wide_mode;
        acc.idx_lo = base;
        acc.idx_hi = base | idx_t'(1);
        acc.d_lo   = wdata[WORD_W-1:0];
        acc.d_hi   = wdata[BUS_W-1:WORD_W];
        acc.be_lo  = wr_ok ? ~lane_we_n[LANES-1:0] : '0;
        acc.be_hi  = (wr_ok && wide_mode) ? ~lane_we_n[BUS_LN-1:LANES] : '0;
    end
endmodule

// File: rtl/dwr_store.sv
module dwr_store
    import dwr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  acc_t acc,
    output word_t rd_lo,
    output word_t rd_hi
);
    word_t mem [LOCS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LOCS; i++)
                mem[i] <= '0;
        end else begin
            if (|acc.be_lo)
                mem[acc.idx_lo] <= merge_bytes(mem[acc.idx_lo], acc.d_lo, acc.be_lo);
            if (|acc.be_hi)
                mem[acc.idx_hi] <= merge_bytes(mem[acc.idx_hi], acc.d_hi, acc.be_hi);
        end
    end

    assign rd_lo = mem[acc.idx_lo];
    assign rd_hi = mem[acc.idx_hi];
endmodule

// File: rtl/dwr_rdreg.sv
module dwr_rdreg
    import dwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             wide,
    input  word_t            rd_lo,
    input  word_t            rd_hi,
    output logic [BUS_W-1:0] rd_q
);
    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (load)
            rd_q <= {wide ? rd_hi : word_t'(0), rd_lo};
    end

    // R6: narrow-mode read leaves the upper half zero
    a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (load && !wide) |=> (rd_q[BUS_W-1:WORD_W] == '0));
endmodule

// File: rtl/dwr_port_top.sv
module dwr_port_top
    import dwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              rd_wr_n,
    input  logic [BUS_LN-1:0] lane_we_n,
    input  logic              byte_en_n,
    input  logic              oe_n,
    output logic [BUS_W-1:0]  rdata,
    output logic              bus_drive
);
    logic             selected;
    acc_t             acc;
    word_t            rd_lo, rd_hi;
    logic [BUS_W-1:0] rd_q;

    dwr_decode u_dec (
        .wide_mode (wide_mode),
        .addr      (addr),
        .wdata     (wdata),
        .sel_a_n   (sel_a_n),
        .sel_b_n   (sel_b_n),
        .sel_c     (sel_c),
        .rd_wr_n   (rd_wr_n),
        .lane_we_n (lane_we_n),
        .byte_en_n (byte_en_n),
        .selected  (selected),
        .acc       (acc)
    );

    dwr_store u_mem (
        .clk   (clk),
        .rst   (rst),
        .acc   (acc),
        .rd_lo (rd_lo),
        .rd_hi (rd_hi)
    );

    dwr_rdreg u_rd (
        .clk   (clk),
        .rst   (rst),
        .load  (acc.rd),
        .wide  (acc.wide),
        .rd_lo (rd_lo),
        .rd_hi (rd_hi),
        .rd_q  (rd_q)
    );

    assign bus_drive = !oe_n;
    assign rdata     = bus_drive ? rd_q : '0;

    // R2: an unselected cycle leaves the read register unchanged
    a_r2_unselected_hold: assert property (@(posedge clk) disable iff (rst)
        (sel_a_n || sel_b_n || !sel_c) |=> $stable(rd_q));

    // R3: a write cycle never reloads the read register
    a_r3_write_no_load: assert property (@(posedge clk) disable iff (rst)
        (!sel_a_n && !sel_b_n && sel_c && !rd_wr_n) |=> $stable(rd_q));

    // R5: lane enables reach storage only for a qualified write
    a_r5_lanes_need_master: assert property (@(posedge clk) disable iff (rst)
        (|{acc.be_hi, acc.be_lo}) |-> (!byte_en_n && !rd_wr_n && selected));

    // R6: upper lanes are inert in narrow mode
    a_r6_no_upper_lanes: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> (acc.be_hi == '0));

    // R7: wide access always pairs an even with the next odd location
    a_r7_pair_aligned: assert property (@(posedge clk) disable iff (rst)
        wide_mode |-> (!acc.idx_lo[0] && acc.idx_hi == (acc.idx_lo | idx_t'(1))));
endmodule

// File: tb/dwr_port_top_tb_top.sv
`timescale 1ns/1ps
module dwr_port_top_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        wide_mode = 0;
    logic [9:0]  addr = '0;
    logic [63:0] wdata = '0;
    logic        sel_a_n = 1, sel_b_n = 1, sel_c = 0;
    logic        rd_wr_n = 1;
    logic [7:0]  lane_we_n = 8'hFF;
    logic        byte_en_n = 1;
    logic        oe_n = 0;
    logic [63:0] rdata;
    logic        bus_drive;

    dwr_port_top dut_i (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .addr(addr), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c), .rd_wr_n(rd_wr_n),
        .lane_we_n(lane_we_n), .byte_en_n(byte_en_n), .oe_n(oe_n),
        .rdata(rdata), .bus_drive(bus_drive)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        logic [63:0] exp;
        string       req;
    } item_t;

    item_t       sb[$];
    logic [31:0] model [1024];
    logic [63:0] last_exp = '0;
    logic        issued = 0;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compares one cycle after each issued read
    always @(posedge clk) begin
        #1;
        if (issued) begin
            if (sb.size() == 0) begin
                check("scoreboard", 64'd1, 64'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.req, rdata, it.exp);
            end
        end
    end

    task automatic set_sel(bit ok, int which);
        sel_a_n = 0; sel_b_n = 0; sel_c = 1;
        if (!ok) begin
            if (which == 0) sel_a_n = 1;
            else if (which == 1) sel_b_n = 1;
            else sel_c = 0;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        set_sel(0, 2);
        sel_a_n = 1; sel_b_n = 1;
        issued = 0;
    endtask

    task automatic wr(bit wide, logic [9:0] a, logic [63:0] d, logic [7:0] ln,
                      bit men_n, bit ok, int which);
        @(negedge clk);
        issued = 0;
        wide_mode = wide; addr = a; wdata = d; lane_we_n = ln;
        byte_en_n = men_n; rd_wr_n = 0;
        set_sel(ok, which);
        if (ok && !men_n) begin
            logic [9:0] e;
            e = wide ? {a[9:1], 1'b0} : a;
            for (int k = 0; k < 4; k++) begin
                if (!ln[k]) model[e][8*k +: 8] = d[8*k +: 8];
                if (wide && !ln[k+4]) model[e | 10'd1][8*k +: 8] = d[32 + 8*k +: 8];
            end
        end
    endtask

    task automatic rd(bit wide, logic [9:0] a, bit ok, string req);
        item_t it;
        @(negedge clk);
        wide_mode = wide; addr = a; rd_wr_n = 1; lane_we_n = 8'hFF; byte_en_n = 1;
        set_sel(ok, 1);
        if (ok) begin
            if (wide) last_exp = {model[{a[9:1], 1'b1}], model[{a[9:1], 1'b0}]};
            else      last_exp = {32'd0, model[a]};
        end
        it.exp = last_exp;
        it.req = req;
        sb.push_back(it);
        issued = 1;
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset contents
        rd(0, 10'd0, 1, "R1");
        rd(0, 10'd600, 1, "R1");
        rd(1, 10'd1023, 1, "R1");
        // R3/R9: basic narrow writes in both areas
        wr(0, 10'd5,   64'hFFFF_FFFF_1234_5678, 8'h00, 0, 1, 0);
        wr(0, 10'd517, 64'h0000_0000_CAFE_F00D, 8'hF0, 0, 1, 0);
        rd(0, 10'd5,   1, "R3");
        rd(0, 10'd517, 1, "R9");
        // R4: single lane
        wr(0, 10'd5, 64'h0000_0000_00AB_0000, 8'hFB, 0, 1, 0);
        rd(0, 10'd5, 1, "R4");
        wr(0, 10'd5, 64'h0000_0000_9900_0011, 8'hF6, 0, 1, 0);
        rd(0, 10'd5, 1, "R4");
        // R6: upper strobes inert, upper read half zero, odd address used
        wr(0, 10'd7, 64'hDEAD_BEEF_0000_0000, 8'h0F, 0, 1, 0);
        rd(0, 10'd7, 1, "R6");
        wr(0, 10'd7, 64'hDEAD_BEEF_7777_0001, 8'h0F & 8'hFC | 8'hF0, 0, 1, 0);
        rd(0, 10'd7, 1, "R6");
        rd(0, 10'd6, 1, "R6");
        // R5: master disable
        wr(0, 10'd5, 64'h0000_0000_5555_5555, 8'h00, 1, 1, 0);
        rd(0, 10'd5, 1, "R5");
        // R2: each enable wrong in turn
        for (int w = 0; w < 3; w++) begin
            wr(0, 10'd517, 64'h0000_0000_1111_1111, 8'h00, 0, 0, w);
            rd(0, 10'd517, 1, "R2");
        end
        rd(0, 10'd5, 1, "R2");
        rd(0, 10'd517, 0, "R2");
        // R7: wide mode pairs
        wr(1, 10'd11, 64'hA1A2_A3A4_B1B2_B3B4, 8'h00, 0, 1, 0);
        rd(0, 10'd10, 1, "R7");
        rd(0, 10'd11, 1, "R7");
        rd(1, 10'd10, 1, "R7");
        wr(1, 10'd10, 64'h00EE_0000_0000_00CC, 8'hBE, 0, 1, 0);
        rd(1, 10'd11, 1, "R7");
        rd(1, 10'd5,  1, "R7");
        idle();
        // R8: output enable gating, no clock involved
        @(negedge clk);
        oe_n = 1;
        #1;
        check("R8", {63'd0, bus_drive}, 64'd0);
        check("R8", rdata, 64'd0);
        wide_mode = 1; addr = 10'd10; rd_wr_n = 1; set_sel(1, 0);
        @(negedge clk);
        set_sel(0, 0);
        #1;
        check("R8", rdata, 64'd0);
        oe_n = 0;
        #1;
        check("R8", {63'd0, bus_drive}, 64'd1);
        check("R8", rdata, {model[11], model[10]});
        // R1: reset clears storage again
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 1024; i++) model[i] = '0;
        last_exp = '0;
        rd(0, 10'd5, 1, "R1");
        rd(1, 10'd10, 1, "R1");
        idle();
        idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule